// File: doc/BRIEF.md
# Multi-Channel DAC Serial Register Interface

This block is the digital control side of a multi-channel digital-to-analog converter. A host reaches it over a four-wire serial link, SPI mode 0, and writes 24-bit command frames. Each channel has three registers: an output code, an offset trim and a gain trim. A small set of special-function registers sits beside them. One is a control word whose bit 0 powers the outputs down. The others are a few reference-group offset registers, each shared by a run of adjacent channels. All register contents leave the block as parallel buses for the converter core. The analog side is not part of the block.

To read a register, the host first sends a request frame that names a register. During the next frame the block shifts that register's value out on MISO. The serial pins are sampled into the system clock domain through synchronizers. SCLK must therefore stay low and high for several system clock cycles per phase. Nothing is changed by a frame until chip select rises after exactly 24 clock edges.

Top module: `dacspi_regif`

## Requirements
- R1: A frame is 24 bits, sent MSB first on MOSI and sampled on rising SCLK. The fields are op = bits 23:22, address = bits 21:16 and payload = bits 15:0. Op 3 writes the payload into the output-code register of channel n, which is addressed as n+8. No other channel changes.
- R2: Op 2 writes the payload into channel n's offset-trim register and op 1 writes it into channel n's gain-trim register. Both use address n+8.
- R3: A frame takes effect only when chip select rises after exactly 24 SCLK rising edges. A frame of any other length leaves every register unchanged.
- R4: Op 0 at address 1 replaces the whole 16-bit control word. The power-down output follows control bit 0.
- R5: Op 0 at addresses 2, 3 and 4 writes the low 14 payload bits into group offset register 0, 1 and 2. A write to a group register the instance does not have is ignored.
- R6: Op 0 at address 5 is a readback request. During the next frame MISO carries 8 zero bits followed by the 16-bit selected value, MSB first, changing after falling SCLK. A frame with no request in front of it returns all zeros. A request is used up by the frame that follows it.
- R7: Request payload bits 15:13 pick the source and bits 12:7 the address. Source 0 and source 1 both return the output code, 2 the offset trim, 3 the gain trim, and 4 a special-function register (1 = control, 2..4 = group offsets, zero-extended). Source values 5..7, unmapped channels and unmapped special addresses return zero.
- R8: Channel n uses group offset register min(n / GRP_SIZE, NGRP-1). Its ch_grp_ofs slice shows that register's value.
- R9: After reset, output codes and offset trims are 0, gain trims are all ones and the control word is 0, so power-down is low.
- R10: Op 0 at address 0 or addresses 6..63, and ops 1..3 at addresses below 8 or at or above 8+NCH, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial readback data to host |
| ch_code | output | NCH*RES_BITS | Output-code register of every channel, channel 0 in the low bits |
| ch_ofs | output | NCH*RES_BITS | Offset-trim register of every channel |
| ch_gain | output | NCH*RES_BITS | Gain-trim register of every channel |
| ch_grp_ofs | output | NCH*14 | Group offset value seen by each channel |
| pwr_down | output | 1 | Power-down flag, control bit 0 |

## Verification
The hardest situation to reach from the pins is a readback that crosses frames. The value returned depends on a request made one frame earlier, and the frame carrying it may itself be a write, another request or a discarded frame of the wrong length. The stimulus reaches this with long random runs that mix requests, writes and malformed frames. A bench model tracks which request is pending and predicts every returned word. Directed runs chain two requests back to back and fill a group register from a channel beyond the last group, so that the clamped mapping is visible.

// File: rtl/dacspi_pkg.sv
package dacspi_pkg;
   localparam int FRAME_W   = 24;
   localparam int FIELD_W   = 16;
   localparam int GOFS_W    = 14;
   localparam int ADDR_W    = 6;
   localparam int CHAN_BASE = 8;
   localparam int MAX_GRP   = 3;

   localparam logic [1:0] OP_SPECIAL = 2'd0;
   localparam logic [1:0] OP_GAIN    = 2'd1;
   localparam logic [1:0] OP_OFFSET  = 2'd2;
   localparam logic [1:0] OP_DATA    = 2'd3;

   localparam logic [ADDR_W-1:0] SF_CTRL  = 6'd1;
   localparam logic [ADDR_W-1:0] SF_GOFS0 = 6'd2;
   localparam logic [ADDR_W-1:0] SF_RDBK  = 6'd5;

   localparam logic [2:0] SRC_CODE     = 3'd0;
   localparam logic [2:0] SRC_CODE_ALT = 3'd1;
   localparam logic [2:0] SRC_OFS      = 3'd2;
   localparam logic [2:0] SRC_GAIN     = 3'd3;
   localparam logic [2:0] SRC_SPECIAL  = 3'd4;

   typedef struct packed {
      logic [1:0]         op;
      logic [ADDR_W-1:0]  addr;
      logic [FIELD_W-1:0] data;
   } frame_t;
endpackage

// File: rtl/dacspi_link.sv
module dacspi_link
   import dacspi_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_i,
   input  logic               cs_n_i,
   input  logic               mosi_i,
   input  logic [FRAME_W-1:0] tx_word_i,
   output logic               frame_start_o,
   output logic               frame_vld_o,
   output logic [FRAME_W-1:0] frame_o,
   output logic               miso_o
);
   localparam int CNT_W = $clog2(FRAME_W + 1) + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES:0]   sclk_p, cs_p;
   logic [SYNC_STAGES-1:0] mosi_p;
   logic [CNT_W-1:0]       cnt_q;
   logic [FRAME_W-1:0]     rx_q, tx_q;
   logic sclk_rise, sclk_fall, cs_act, cs_stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_p <= '0;
         cs_p   <= '1;
         mosi_p <= '0;
      end else begin
         sclk_p <= {sclk_p[SYNC_STAGES-1:0], sclk_i};
         cs_p   <= {cs_p[SYNC_STAGES-1:0], cs_n_i};
         mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi_i};
      end
   end

   assign sclk_rise     = sclk_p[SYNC_STAGES-1] & ~sclk_p[SYNC_STAGES];
   assign sclk_fall     = ~sclk_p[SYNC_STAGES-1] & sclk_p[SYNC_STAGES];
   assign cs_act        = ~cs_p[SYNC_STAGES-1];
   assign frame_start_o = cs_act & cs_p[SYNC_STAGES];
   assign cs_stop       = ~cs_act & ~cs_p[SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rx_q  <= '0;
         tx_q  <= '0;
      end else begin
         if (frame_start_o) begin
            cnt_q <= '0;
            tx_q  <= tx_word_i;
         end else if (cs_act) begin
            if (sclk_rise) begin
               rx_q <= {rx_q[FRAME_W-2:0], mosi_p[SYNC_STAGES-1]};
               if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end
            if (sclk_fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
         end
      end
   end

   assign frame_vld_o = cs_stop && (cnt_q == CNT_W'(FRAME_W));
   assign frame_o     = rx_q;
   assign miso_o      = cs_act & tx_q[FRAME_W-1];

   // R3
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld_o |=> !frame_vld_o);
   // R3
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |=> (cnt_q == '0));
endmodule

// File: rtl/dacspi_chan_regs.sv
module dacspi_chan_regs
   import dacspi_pkg::*;
#(
   parameter int NCH      = 16,
   parameter int RES_BITS = 16,
   parameter int CHW      = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en_i,
   input  logic [1:0]              wr_op_i,
   input  logic [CHW-1:0]          wr_ch_i,
   input  logic [FIELD_W-1:0]      wr_data_i,
   input  logic [1:0]              rd_op_i,
   input  logic [CHW-1:0]          rd_ch_i,
   output logic [FIELD_W-1:0]      rd_val_o,
   output logic [NCH*RES_BITS-1:0] code_o,
   output logic [NCH*RES_BITS-1:0] ofs_o,
   output logic [NCH*RES_BITS-1:0] gain_o
);
   logic [RES_BITS-1:0] code_q [NCH];
   logic [RES_BITS-1:0] ofs_q  [NCH];
   logic [RES_BITS-1:0] gain_q [NCH];
   logic [RES_BITS-1:0] fld, rd_raw;

   assign fld = wr_data_i[FIELD_W-1 -: RES_BITS];

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_q[i] <= '0;
            ofs_q[i]  <= '0;
            gain_q[i] <= '1;
         end else if (wr_en_i && wr_ch_i == CHW'(i)) begin
            case (wr_op_i)
               OP_DATA:   code_q[i] <= fld;
               OP_OFFSET: ofs_q[i]  <= fld;
               OP_GAIN:   gain_q[i] <= fld;
               default:   ;
            endcase
         end
      end
      assign code_o[i*RES_BITS +: RES_BITS] = code_q[i];
      assign ofs_o[i*RES_BITS +: RES_BITS]  = ofs_q[i];
      assign gain_o[i*RES_BITS +: RES_BITS] = gain_q[i];
   end

   always_comb begin
      rd_raw = '0;
      for (int i = 0; i < NCH; i++) begin
         if (rd_ch_i == CHW'(i)) begin
            case (rd_op_i)
               OP_DATA:   rd_raw = code_q[i];
               OP_OFFSET: rd_raw = ofs_q[i];
               OP_GAIN:   rd_raw = gain_q[i];
               default:   rd_raw = '0;
            endcase
         end
      end
   end

   if (RES_BITS == FIELD_W) begin : g_full
      assign rd_val_o = rd_raw;
   end else begin : g_pad
      assign rd_val_o = {rd_raw, {(FIELD_W-RES_BITS){1'b0}}};
   end
endmodule

// File: rtl/dacspi_grp_regs.sv
module dacspi_grp_regs
   import dacspi_pkg::*;
#(
   parameter int NCH      = 16,
   parameter int GRP_SIZE = 8,
   parameter int NGRP     = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en_i,
   input  logic [1:0]            wr_idx_i,
   input  logic [GOFS_W-1:0]     wr_val_i,
   input  logic [1:0]            rd_idx_i,
   output logic [GOFS_W-1:0]     rd_val_o,
   output logic [NCH*GOFS_W-1:0] ch_gofs_o
);
   logic [GOFS_W-1:0] gq [NGRP];

   for (genvar g = 0; g < NGRP; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                gq[g] <= '0;
         else if (wr_en_i && wr_idx_i == 2'(g))     gq[g] <= wr_val_i;
      end
   end

   always_comb begin
      rd_val_o = '0;
      for (int g = 0; g < NGRP; g++)
         if (rd_idx_i == 2'(g)) rd_val_o = gq[g];
   end

   for (genvar i = 0; i < NCH; i++) begin : g_map
      localparam int RAW = i / GRP_SIZE;
      localparam int GI  = (RAW >= NGRP) ? NGRP - 1 : RAW;
      assign ch_gofs_o[i*GOFS_W +: GOFS_W] = gq[GI];
   end
endmodule

// File: rtl/dacspi_regif.sv
module dacspi_regif
   import dacspi_pkg::*;
#(
   parameter int NCH      = 16,
   parameter int RES_BITS = 16,
   parameter int GRP_SIZE = 8,
   parameter int NGRP     = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    spi_sclk,
   input  logic                    spi_cs_n,
   input  logic                    spi_mosi,
   output logic                    spi_miso,
   output logic [NCH*RES_BITS-1:0] ch_code,
   output logic [NCH*RES_BITS-1:0] ch_ofs,
   output logic [NCH*RES_BITS-1:0] ch_gain,
   output logic [NCH*GOFS_W-1:0]   ch_grp_ofs,
   output logic                    pwr_down
);
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

   if (NCH < 1 || NCH > (1 << ADDR_W) - CHAN_BASE) begin : g_bad_nch
      $error("NCH out of range");
   end
   if (RES_BITS != 14 && RES_BITS != 16) begin : g_bad_res
      $error("RES_BITS must be 14 or 16");
   end
   if (NGRP < 1 || NGRP > MAX_GRP) begin : g_bad_grp
      $error("NGRP must be 1..3");
   end
   if (GRP_SIZE < 1) begin : g_bad_gs
      $error("GRP_SIZE must be positive");
   end

   logic               frame_start, frame_vld;
   logic [FRAME_W-1:0] frame_raw, tx_word;
   frame_t             fr;
   logic               rb_pend_q;
   logic [FIELD_W-1:0] rb_word_q, ctrl_q;

   dacspi_link u_link (
      .clk           (clk),
      .rst_n         (rst_n),
      .sclk_i        (spi_sclk),
      .cs_n_i        (spi_cs_n),
      .mosi_i        (spi_mosi),
      .tx_word_i     (tx_word),
      .frame_start_o (frame_start),
      .frame_vld_o   (frame_vld),
      .frame_o       (frame_raw),
      .miso_o        (spi_miso)
   );

   assign fr      = frame_t'(frame_raw);
   assign tx_word = rb_pend_q ? {{(FRAME_W-FIELD_W){1'b0}}, rb_word_q} : '0;

   // write decode
   logic [ADDR_W-1:0] ch_off, g_off;
   logic ch_ok, g_ok, sf_acc, chan_wr, grp_wr;

   assign ch_off  = fr.addr - ADDR_W'(CHAN_BASE);
   assign ch_ok   = (fr.addr >= ADDR_W'(CHAN_BASE)) && (ch_off < ADDR_W'(NCH));
   assign g_off   = fr.addr - SF_GOFS0;
   assign g_ok    = (fr.addr >= SF_GOFS0) && (g_off < ADDR_W'(NGRP));
   assign sf_acc  = frame_vld && (fr.op == OP_SPECIAL);
   assign chan_wr = frame_vld && (fr.op != OP_SPECIAL) && ch_ok;
   assign grp_wr  = sf_acc && g_ok;

   // readback decode
   logic [2:0]         rb_src;
   logic [ADDR_W-1:0]  rb_addr, rb_choff, rb_goff;
   logic               rb_chok, rb_gok;
   logic [1:0]         rd_op;
   logic [FIELD_W-1:0] chan_rd, rb_val;
   logic [GOFS_W-1:0]  grp_rd;

   assign rb_src   = fr.data[15:13];
   assign rb_addr  = fr.data[12:7];
   assign rb_choff = rb_addr - ADDR_W'(CHAN_BASE);
   assign rb_chok  = (rb_addr >= ADDR_W'(CHAN_BASE)) && (rb_choff < ADDR_W'(NCH));
   assign rb_goff  = rb_addr - SF_GOFS0;
   assign rb_gok   = (rb_addr >= SF_GOFS0) && (rb_goff < ADDR_W'(NGRP));

   always_comb begin
      case (rb_src)
         SRC_CODE, SRC_CODE_ALT: rd_op = OP_DATA;
         SRC_OFS:                rd_op = OP_OFFSET;
         SRC_GAIN:               rd_op = OP_GAIN;
         default:                rd_op = OP_SPECIAL;
      endcase
   end

   dacspi_chan_regs #(.NCH(NCH), .RES_BITS(RES_BITS), .CHW(CHW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (chan_wr),
      .wr_op_i   (fr.op),
      .wr_ch_i   (ch_off[CHW-1:0]),
      .wr_data_i (fr.data),
      .rd_op_i   (rd_op),
      .rd_ch_i   (rb_choff[CHW-1:0]),
      .rd_val_o  (chan_rd),
      .code_o    (ch_code),
      .ofs_o     (ch_ofs),
      .gain_o    (ch_gain)
   );

   dacspi_grp_regs #(.NCH(NCH), .GRP_SIZE(GRP_SIZE), .NGRP(NGRP)) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (grp_wr),
      .wr_idx_i  (g_off[1:0]),
      .wr_val_i  (fr.data[GOFS_W-1:0]),
      .rd_idx_i  (rb_goff[1:0]),
      .rd_val_o  (grp_rd),
      .ch_gofs_o (ch_grp_ofs)
   );

   always_comb begin
      rb_val = '0;
      case (rb_src)
         SRC_CODE, SRC_CODE_ALT, SRC_OFS, SRC_GAIN:
            if (rb_chok) rb_val = chan_rd;
         SRC_SPECIAL:
            if (rb_addr == SF_CTRL) rb_val = ctrl_q;
            else if (rb_gok)        rb_val = {{(FIELD_W-GOFS_W){1'b0}}, grp_rd};
         default: rb_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         rb_pend_q <= 1'b0;
         rb_word_q <= '0;
      end else begin
         if (sf_acc && fr.addr == SF_CTRL) ctrl_q <= fr.data;
         if (frame_start) begin
            rb_pend_q <= 1'b0;
         end else if (sf_acc && fr.addr == SF_RDBK) begin
            rb_pend_q <= 1'b1;
            rb_word_q <= rb_val;
         end
      end
   end

   assign pwr_down = ctrl_q[0];

   // R4
   pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_vld |=> $stable(pwr_down));
   // R3
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_vld |=> $stable(ch_code) && $stable(ch_ofs) && $stable(ch_gain));
   // R6
   rb_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !rb_pend_q);
   // R5
   grp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_vld |=> $stable(ch_grp_ofs));
endmodule

// File: tb/sim_dacspi_regif.sv
module sim_dacspi_regif;
   localparam int CLK_PER = 10;
   localparam int HALF    = 6;
   localparam int NCH     = 16;
   localparam int RES     = 16;
   localparam int GS      = 4;
   localparam int NG      = 3;
   localparam int WD      = 150000;

   logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
   logic miso, pwr;
   logic [NCH*16-1:0] code, ofs, gain;
   logic [NCH*14-1:0] gofs;

   always #(CLK_PER/2) clk = ~clk;

   dacspi_regif #(.NCH(NCH), .RES_BITS(RES), .GRP_SIZE(GS), .NGRP(NG)) u0 (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
      .spi_mosi(mosi), .spi_miso(miso), .ch_code(code), .ch_ofs(ofs),
      .ch_gain(gain), .ch_grp_ofs(gofs), .pwr_down(pwr));

   int n_vec = 0, n_bad = 0, cyc = 0;
   logic [15:0] m_code [NCH];
   logic [15:0] m_ofs  [NCH];
   logic [15:0] m_gain [NCH];
   logic [13:0] m_grp  [NG];
   logic [15:0] m_ctrl;
   logic        m_pend;
   logic [15:0] m_rb;

   always @(posedge clk) begin
      cyc++;
      if (cyc == WD) begin
         n_bad++;
         $display("FAIL watchdog (all reqs) actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic int grp_of(input int ch);
      int g = ch / GS;
      return (g >= NG) ? NG - 1 : g;
   endfunction

   function automatic logic [15:0] exp_rb(input logic [2:0] src, input logic [5:0] a);
      int c = int'(a) - 8;
      bit cok = (a >= 8) && (c < NCH);
      case (src)
         3'd0, 3'd1: return cok ? m_code[c] : 16'h0;
         3'd2:       return cok ? m_ofs[c]  : 16'h0;
         3'd3:       return cok ? m_gain[c] : 16'h0;
         3'd4: begin
            if (a == 6'd1) return m_ctrl;
            if (a >= 6'd2 && int'(a) - 2 < NG) return {2'b00, m_grp[int'(a)-2]};
            return 16'h0;
         end
         default: return 16'h0;
      endcase
   endfunction

   task automatic check_outputs(input string req);
      logic [NCH*16-1:0] ec, eo, eg;
      logic [NCH*14-1:0] ex;
      for (int i = 0; i < NCH; i++) begin
         ec[i*16 +: 16] = m_code[i];
         eo[i*16 +: 16] = m_ofs[i];
         eg[i*16 +: 16] = m_gain[i];
         ex[i*14 +: 14] = m_grp[grp_of(i)];
      end
      chk(code == ec, req, "ch_code", 256'(code), 256'(ec));
      chk(ofs == eo, req, "ch_ofs", 256'(ofs), 256'(eo));
      chk(gain == eg, req, "ch_gain", 256'(gain), 256'(eg));
      chk(gofs == ex, {req, "/R8"}, "ch_grp_ofs", 256'(gofs), 256'(ex));
      chk(pwr == m_ctrl[0], {req, "/R4"}, "pwr_down", 256'(pwr), 256'(m_ctrl[0]));
   endtask

   task automatic xfer(input logic [23:0] w, input int nbits, output logic [23:0] got);
      got = '0;
      @(negedge clk) cs_n = 0;
      for (int i = 0; i < nbits; i++) begin
         mosi = (i < 24) ? w[23-i] : 1'b1;
         repeat (HALF) @(negedge clk);
         if (i < 24) got = {got[22:0], miso};
         sclk = 1;
         repeat (HALF) @(negedge clk);
         sclk = 0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1;
      mosi = 0;
      repeat (10) @(negedge clk);
   endtask

   task automatic frame(input logic [23:0] w, input int nbits, input string req);
      logic [23:0] got;
      logic [1:0] op = w[23:22];
      logic [5:0] a = w[21:16];
      logic [15:0] d = w[15:0];
      bit had = m_pend;
      logic [15:0] want = m_pend ? m_rb : 16'h0;
      int c = int'(a) - 8;
      xfer(w, nbits, got);
      m_pend = 0;
      if (nbits >= 24)
         chk(got == {8'h00, want}, had ? "R6/R7 readback" : "R6 idle miso",
             "miso word", 256'(got), 256'({8'h00, want}));
      if (nbits == 24) begin
         if (op != 2'd0) begin
            if (a >= 8 && c < NCH) begin
               if (op == 2'd3) m_code[c] = d;
               else if (op == 2'd2) m_ofs[c] = d;
               else m_gain[c] = d;
            end
         end else if (a == 6'd1) m_ctrl = d;
         else if (a >= 6'd2 && int'(a) - 2 < NG) m_grp[int'(a)-2] = d[13:0];
         else if (a == 6'd5) begin
            m_pend = 1;
            m_rb = exp_rb(d[15:13], d[12:7]);
         end
      end
      check_outputs(req);
   endtask

   function automatic logic [23:0] mk(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
      return {op, a, d};
   endfunction

   function automatic logic [15:0] rq(input logic [2:0] src, input logic [5:0] a);
      return {src, a, 7'h00};
   endfunction

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NCH; i++) begin
         m_code[i] = 0; m_ofs[i] = 0; m_gain[i] = 16'hFFFF;
      end
      for (int g = 0; g < NG; g++) m_grp[g] = 0;
      m_ctrl = 0; m_pend = 0; m_rb = 0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);
      // R9 reset state
      check_outputs("R9");
      frame(mk(2'd0, 6'd5, rq(3'd3, 6'd11)), 24, "R9");
      frame(mk(2'd0, 6'd0, 16'h1234), 24, "R10 nop");
      // R1 data write, R2 trims
      frame(mk(2'd3, 6'd13, 16'hA5C3), 24, "R1");
      frame(mk(2'd2, 6'd8, 16'h0F0F), 24, "R2");
      frame(mk(2'd1, 6'd23, 16'h7001), 24, "R2");
      // R6 chained readbacks, R7 alias source
      frame(mk(2'd0, 6'd5, rq(3'd0, 6'd13)), 24, "R6");
      frame(mk(2'd0, 6'd5, rq(3'd1, 6'd13)), 24, "R7");
      frame(mk(2'd0, 6'd5, rq(3'd2, 6'd8)), 24, "R7");
      frame(mk(2'd3, 6'd9, 16'h0001), 24, "R6");
      // R4 control replace
      frame(mk(2'd0, 6'd1, 16'h0001), 24, "R4");
      frame(mk(2'd0, 6'd1, 16'h8002), 24, "R4");
      frame(mk(2'd0, 6'd5, rq(3'd4, 6'd1)), 24, "R4");
      // R5 / R8 group registers and clamp
      frame(mk(2'd0, 6'd4, 16'hFFFF), 24, "R5");
      frame(mk(2'd0, 6'd2, 16'hC123), 24, "R5");
      frame(mk(2'd0, 6'd5, rq(3'd4, 6'd4)), 24, "R8");
      // R3 wrong lengths
      frame(mk(2'd3, 6'd8, 16'hBEEF), 23, "R3");
      frame(mk(2'd3, 6'd8, 16'hBEEF), 25, "R3");
      frame(mk(2'd0, 6'd1, 16'h0000), 23, "R3");
      // R10 unused addresses, R7 unmapped readback
      frame(mk(2'd0, 6'd6, 16'hFFFF), 24, "R10");
      frame(mk(2'd3, 6'd7, 16'hFFFF), 24, "R10");
      frame(mk(2'd3, 6'd24, 16'hFFFF), 24, "R10");
      frame(mk(2'd0, 6'd5, rq(3'd0, 6'd30)), 24, "R7");
      frame(mk(2'd0, 6'd5, rq(3'd5, 6'd9)), 24, "R7");
      frame(mk(2'd0, 6'd5, rq(3'd4, 6'd6)), 24, "R7");
      frame(mk(2'd0, 6'd0, 16'h0000), 24, "R7");
      // random mix
      for (int k = 0; k < 170; k++) begin
         int kind = $urandom % 10;
         logic [5:0] ca = 6'(8 + ($urandom % NCH));
         logic [15:0] d = 16'($urandom);
         case (kind)
            0, 1, 2: frame(mk(2'd3, ca, d), 24, "R1");
            3:       frame(mk(2'd2, ca, d), 24, "R2");
            4:       frame(mk(2'd1, ca, d), 24, "R2");
            5: begin
               logic [2:0] s = 3'($urandom % 8);
               logic [5:0] a = (s == 3'd4) ? 6'($urandom % 7) : ca;
               frame(mk(2'd0, 6'd5, rq(s, a)), 24, "R7");
            end
            6:       frame(mk(2'd0, 6'd1, d), 24, "R4");
            7:       frame(mk(2'd0, 6'(2 + ($urandom % 3)), d), 24, "R5");
            8:       frame(24'($urandom), 24, "R10");
            default: frame(24'($urandom), ($urandom % 2) ? 23 : 25, "R3");
         endcase
      end
      frame(mk(2'd0, 6'd0, 16'h0000), 24, "R6");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule